// File: doc/BRIEF.md
# Completion Queue Posting Engine

This block owns the producer side of one completion ring that lives in host memory. Finished commands arrive on a valid/ready port, each carrying a command identifier, the identifier of the submission ring it came from, that ring's current head index and a status code. The block keeps them in a small in-order buffer and turns each one into a 16-byte completion entry. It computes the host address of the slot the entry belongs in and presents the entry on a memory-write request port, one write at a time.

The block tracks the ring's tail (producer), its head (consumer) and a phase tag. The tail moves forward only when the memory side accepts a write. The phase tag inverts each time the tail wraps, and it is folded into bit 0 of the entry's status word so the host can tell fresh entries from stale ones. The host frees slots by writing a new head value through a doorbell input. The block never fills the last free slot, so posting pauses while the ring is one entry short of full. When a run of posts ends, it raises one interrupt: a vector message when vector interrupts are on, otherwise a single-cycle pin pulse.

Top module: `cq_post_engine`

## Requirements
- R1: After reset the tail and head are 0 and the phase tag is 1: `wr_valid` is low, `cpl_ready` is high, and the first entry is written to `cfg_base` with status bit 0 set.
- R2: The 128-bit entry is laid out as bits [127:113] status code, bit [112] phase tag, [111:96] command id, [95:80] submission-ring id, [79:64] submission-ring head, and bits [63:0] zero.
- R3: The write address is `cfg_base + tail * 2^CQE_EXP`, which is 16 bytes per slot by default.
- R4: Each accepted write moves the tail up by one. When the tail reaches `cfg_qsize` it returns to 0, and the phase tag inverts at that point.
- R5: While (tail + 1) mod `cfg_qsize` equals head, no write is issued and pending completions stay buffered. Posting resumes after a doorbell frees a slot.
- R6: A doorbell whose value is at or above `cfg_qsize` is ignored, and head keeps its old value.
- R7: At most one write is outstanding. `wr_valid`, `wr_addr` and `wr_data` hold steady until `wr_ready`, and the tail does not move without an accepted write.
- R8: A post is followed by an interrupt once no further post can start, so a back-to-back run gives one interrupt. The interrupt is a one-cycle `msix_valid` with `msix_vector` = `cfg_vector` when `cfg_irq_en` and `cfg_msix_en` are set. It is a one-cycle `pin_pulse` when only `cfg_irq_en` is set, and nothing when `cfg_irq_en` is clear.
- R9: Completions are written in arrival order. `cpl_ready` drops once `PEND_DEPTH` completions are buffered; the write register holds one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Host byte address of ring slot 0 |
| cfg_qsize | input | QIDX_W | Number of ring slots (2 or more) |
| cfg_irq_en | input | 1 | Interrupts enabled for this ring |
| cfg_msix_en | input | 1 | Use vector messages instead of the pin |
| cfg_vector | input | VEC_W | Vector number for message interrupts |
| cpl_valid | input | 1 | Completion request valid |
| cpl_ready | output | 1 | Completion request accepted this cycle |
| cpl_cid | input | 16 | Command identifier |
| cpl_sqid | input | 16 | Originating submission-ring id |
| cpl_sqhead | input | 16 | Current head of that submission ring |
| cpl_code | input | 15 | Status code |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 128 | Completion entry |
| db_valid | input | 1 | Head doorbell strobe |
| db_head | input | QIDX_W | New head value |
| msix_valid | output | 1 | One-cycle vector interrupt request |
| msix_vector | output | VEC_W | Vector for the request |
| pin_pulse | output | 1 | One-cycle pin interrupt pulse |

## Verification
The bench drives a four-slot ring into the one-short-of-full state and then tries a doorbell beyond the ring size. A design that tested fullness as head equal to tail would overwrite an unread slot, and one that took the bad doorbell would post into a slot that is not free. It then posts across the wrap, where a phase tag that flipped on the wrong edge would mark the next entry with stale status bit 0, and it holds `wr_ready` low to catch a tail that moves before acceptance or a payload that changes while waiting. Back-to-back posts must give exactly one interrupt, and each enable setting must give the right interrupt kind or none. A long random run with a cycle model compares every output on every clock, which also shows any reordering or buffer-full miscount.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

   localparam int ENTRY_W = 128;
   localparam int CODE_W  = 15;
   localparam int ID_W    = 16;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [ID_W-1:0]   cid;
      logic [ID_W-1:0]   sqid;
      logic [ID_W-1:0]   sqhead;
   } cqp_req_t;

   localparam int REQ_W = $bits(cqp_req_t);

   // Status word is {code, phase}; lower 64 bits carry no command result.
   function automatic logic [ENTRY_W-1:0] cqp_build(input cqp_req_t r, input logic ph);
      return {r.code, ph, r.cid, r.sqid, r.sqhead, 64'd0};
   endfunction

endpackage

// File: rtl/cqp_pend_fifo.sv
module cqp_pend_fifo #(
   parameter int W     = 63,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   generate
      if (DEPTH == 1) begin : g_single
         logic         vld;
         logic [W-1:0] hold;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    vld <= 1'b0;
            else if (push) vld <= 1'b1;
            else if (pop)  vld <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (push) hold <= din;
         end

         assign dout  = hold;
         assign empty = !vld;
         assign full  = vld;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);

         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] rd_p, wr_p;
         logic [CNT_W-1:0] cnt;

         function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_p <= '0;
               wr_p <= '0;
               cnt  <= '0;
            end else begin
               if (push) wr_p <= step(wr_p);
               if (pop)  rd_p <= step(rd_p);
               case ({push, pop})
                  2'b10:   cnt <= cnt + 1'b1;
                  2'b01:   cnt <= cnt - 1'b1;
                  default: cnt <= cnt;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem[wr_p] <= din;
         end

         assign dout  = mem[rd_p];
         assign empty = (cnt == '0);
         assign full  = (cnt == CNT_W'(DEPTH));
      end
   endgenerate

endmodule

// File: rtl/cqp_ring_ptr.sv
module cqp_ring_ptr #(
   parameter int QIDX_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [QIDX_W-1:0] qsize,
   input  logic              advance,
   input  logic              db_valid,
   input  logic [QIDX_W-1:0] db_head,
   output logic [QIDX_W-1:0] tail,
   output logic [QIDX_W-1:0] head,
   output logic              phase,
   output logic              ring_full
);

   logic [QIDX_W-1:0] tail_inc;
   logic              tail_wrap;
   logic [QIDX_W-1:0] tail_nxt;

   assign tail_inc  = tail + 1'b1;
   assign tail_wrap = (tail_inc == qsize);
   assign tail_nxt  = tail_wrap ? '0 : tail_inc;
   assign ring_full = (tail_nxt == head);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail  <= '0;
         phase <= 1'b1;
      end else if (advance) begin
         tail <= tail_nxt;
         if (tail_wrap) phase <= !phase;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          head <= '0;
      else if (db_valid && db_head < qsize) head <= db_head;
   end

endmodule

// File: rtl/cqp_irq_gen.sv
module cqp_irq_gen #(
   parameter int VEC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_done,
   input  logic             wr_busy,
   input  logic             more_ready,
   input  logic             irq_en,
   input  logic             msix_en,
   input  logic [VEC_W-1:0] vec_in,
   output logic             msix_valid,
   output logic [VEC_W-1:0] msix_vector,
   output logic             pin_pulse
);

   logic armed;
   logic fire;

   // The batch ends when nothing is in flight and nothing can start now.
   assign fire = armed && !wr_busy && !more_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed       <= 1'b0;
         msix_valid  <= 1'b0;
         msix_vector <= '0;
         pin_pulse   <= 1'b0;
      end else begin
         if (wr_done)   armed <= 1'b1;
         else if (fire) armed <= 1'b0;
         msix_valid <= fire && irq_en && msix_en;
         pin_pulse  <= fire && irq_en && !msix_en;
         if (fire && irq_en && msix_en) msix_vector <= vec_in;
      end
   end

endmodule

// File: rtl/cq_post_engine.sv
module cq_post_engine
   import cqp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int QIDX_W     = 12,
   parameter int PEND_DEPTH = 4,
   parameter int VEC_W      = 5,
   parameter int CQE_EXP    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [QIDX_W-1:0]  cfg_qsize,
   input  logic               cfg_irq_en,
   input  logic               cfg_msix_en,
   input  logic [VEC_W-1:0]   cfg_vector,
   input  logic               cpl_valid,
   output logic               cpl_ready,
   input  logic [15:0]        cpl_cid,
   input  logic [15:0]        cpl_sqid,
   input  logic [15:0]        cpl_sqhead,
   input  logic [14:0]        cpl_code,
   output logic               wr_valid,
   input  logic               wr_ready,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [ENTRY_W-1:0] wr_data,
   input  logic               db_valid,
   input  logic [QIDX_W-1:0]  db_head,
   output logic               msix_valid,
   output logic [VEC_W-1:0]   msix_vector,
   output logic               pin_pulse
);

   generate
      if (QIDX_W < 2)                   begin : g_bad_idx   $error("QIDX_W must be at least 2"); end
      if (PEND_DEPTH < 1)               begin : g_bad_depth $error("PEND_DEPTH must be at least 1"); end
      if (CQE_EXP < 4 || CQE_EXP > 12)  begin : g_bad_exp   $error("CQE_EXP out of range"); end
      if (ADDR_W < QIDX_W + CQE_EXP)    begin : g_bad_addr  $error("ADDR_W too small for ring span"); end
   endgenerate

   cqp_req_t          req_in, req_head;
   logic              fifo_empty, fifo_full, fifo_push, fifo_pop;
   logic [QIDX_W-1:0] ring_tail, ring_head;
   logic              ring_phase, ring_full;
   logic              accept, load;

   assign req_in    = '{code: cpl_code, cid: cpl_cid, sqid: cpl_sqid, sqhead: cpl_sqhead};
   assign cpl_ready = !fifo_full;
   assign fifo_push = cpl_valid && cpl_ready;
   assign accept    = wr_valid && wr_ready;
   assign load      = !wr_valid && !fifo_empty && !ring_full;
   assign fifo_pop  = load;

   cqp_pend_fifo #(.W(REQ_W), .DEPTH(PEND_DEPTH)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .din   (req_in),
      .pop   (fifo_pop),
      .dout  (req_head),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   cqp_ring_ptr #(.QIDX_W(QIDX_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .qsize     (cfg_qsize),
      .advance   (accept),
      .db_valid  (db_valid),
      .db_head   (db_head),
      .tail      (ring_tail),
      .head      (ring_head),
      .phase     (ring_phase),
      .ring_full (ring_full)
   );

   // Write request register: filled from the buffer, emptied on accept.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_valid <= 1'b0;
      else if (load)   wr_valid <= 1'b1;
      else if (accept) wr_valid <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_addr <= '0;
         wr_data <= '0;
      end else if (load) begin
         wr_addr <= cfg_base + (ADDR_W'(ring_tail) << CQE_EXP);
         wr_data <= cqp_build(req_head, ring_phase);
      end
   end

   cqp_irq_gen #(.VEC_W(VEC_W)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_done     (accept),
      .wr_busy     (wr_valid),
      .more_ready  (!fifo_empty && !ring_full),
      .irq_en      (cfg_irq_en),
      .msix_en     (cfg_msix_en),
      .vec_in      (cfg_vector),
      .msix_valid  (msix_valid),
      .msix_vector (msix_vector),
      .pin_pulse   (pin_pulse)
   );

endmodule

// File: rtl/cqp_checker.sv
module cqp_checker #(
   parameter int ADDR_W = 32,
   parameter int QIDX_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [127:0]      wr_data,
   input logic              msix_valid,
   input logic              pin_pulse,
   input logic [QIDX_W-1:0] tail,
   input logic [QIDX_W-1:0] head,
   input logic [QIDX_W-1:0] qsize,
   input logic              phase,
   input logic              ring_full
);

   a_r7_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   a_r7_tail_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && wr_ready) |=> $stable(tail));

   a_r4_phase_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase) |-> tail == '0);

   a_r5_no_post_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid && ring_full |=> !wr_valid);

   a_r6_head_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      head < qsize);

   a_r2_phase_in_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> wr_data[112] == $past(phase));

   a_r2_low_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_data[63:0] == 64'd0);

   a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(msix_valid && pin_pulse));

   a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (msix_valid || pin_pulse) |=> !(msix_valid || pin_pulse));

endmodule

bind cq_post_engine cqp_checker #(.ADDR_W(ADDR_W), .QIDX_W(QIDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .msix_valid (msix_valid),
   .pin_pulse  (pin_pulse),
   .tail       (ring_tail),
   .head       (ring_head),
   .qsize      (cfg_qsize),
   .phase      (ring_phase),
   .ring_full  (ring_full)
);

// File: tb/sim_cq_post_engine.sv
module sim_cq_post_engine;

   localparam int ADDR_W = 32;
   localparam int QIDX_W = 12;
   localparam int DEPTH  = 4;
   localparam int VEC_W  = 5;
   localparam int QSZ    = 4;
   localparam logic [31:0] BASE = 32'h0000_1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = !clk;

   logic              cfg_irq_en = 1'b1, cfg_msix_en = 1'b1;
   logic [VEC_W-1:0]  cfg_vector = 5'd3;
   logic              cpl_valid = 1'b0, cpl_ready;
   logic [15:0]       cpl_cid = '0, cpl_sqid = '0, cpl_sqhead = '0;
   logic [14:0]       cpl_code = '0;
   logic              wr_valid, wr_ready = 1'b1;
   logic [ADDR_W-1:0] wr_addr;
   logic [127:0]      wr_data;
   logic              db_valid = 1'b0;
   logic [QIDX_W-1:0] db_head = '0;
   logic              msix_valid, pin_pulse;
   logic [VEC_W-1:0]  msix_vector;

   cq_post_engine #(.ADDR_W(ADDR_W), .QIDX_W(QIDX_W), .PEND_DEPTH(DEPTH),
                    .VEC_W(VEC_W), .CQE_EXP(4)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_qsize(12'(QSZ)),
      .cfg_irq_en(cfg_irq_en), .cfg_msix_en(cfg_msix_en), .cfg_vector(cfg_vector),
      .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_cid(cpl_cid),
      .cpl_sqid(cpl_sqid), .cpl_sqhead(cpl_sqhead), .cpl_code(cpl_code),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .db_valid(db_valid), .db_head(db_head),
      .msix_valid(msix_valid), .msix_vector(msix_vector), .pin_pulse(pin_pulse));

   int n_cmp = 0, n_bad = 0;
   bit started = 1'b0;

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [62:0]  pq[$];
   logic [62:0]  pitem;
   int           m_tail, m_head, m_nt;
   bit           m_ph, m_wv, m_ip, m_msix, m_pin, m_full, m_acc, m_ld, m_fire, m_push;
   logic [31:0]  m_addr;
   logic [127:0] m_data;
   logic [4:0]   m_vec;

   always @(posedge clk) begin
      if (!rst_n) begin
         pq.delete();
         m_tail = 0; m_head = 0; m_ph = 1'b1; m_wv = 1'b0; m_ip = 1'b0;
         m_msix = 1'b0; m_pin = 1'b0; m_addr = '0; m_data = '0; m_vec = '0;
      end else begin
         m_nt   = (m_tail + 1 == QSZ) ? 0 : m_tail + 1;
         m_full = (m_nt == m_head);
         m_acc  = m_wv && wr_ready;
         m_ld   = !m_wv && pq.size() > 0 && !m_full;
         m_fire = !m_wv && m_ip && (pq.size() == 0 || m_full);
         m_push = cpl_valid && pq.size() < DEPTH;
         m_msix = 1'b0; m_pin = 1'b0;
         if (m_fire) begin
            m_ip = 1'b0;
            if (cfg_irq_en && cfg_msix_en) begin m_msix = 1'b1; m_vec = cfg_vector; end
            else if (cfg_irq_en) m_pin = 1'b1;
         end
         if (m_acc) begin
            m_wv = 1'b0; m_ip = 1'b1;
            if (m_nt == 0) m_ph = !m_ph;
            m_tail = m_nt;
         end
         if (m_ld) begin
            pitem  = pq.pop_front();
            m_addr = BASE + 32'(m_tail * 16);
            m_data = {pitem[62:48], m_ph, pitem[47:0], 64'd0};
            m_wv   = 1'b1;
         end
         if (db_valid && int'(db_head) < QSZ) m_head = int'(db_head);
         if (m_push) pq.push_back({cpl_code, cpl_cid, cpl_sqid, cpl_sqhead});
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         check("R9 cpl_ready", 128'(cpl_ready), 128'(pq.size() < DEPTH));
         check("R7 wr_valid", 128'(wr_valid), 128'(m_wv));
         if (m_wv) begin
            check("R3 wr_addr", 128'(wr_addr), 128'(m_addr));
            check("R2 wr_data", wr_data, m_data);
         end
         check("R8 msix_valid", 128'(msix_valid), 128'(m_msix));
         check("R8 pin_pulse", 128'(pin_pulse), 128'(m_pin));
         if (m_msix) check("R8 msix_vector", 128'(msix_vector), 128'(m_vec));
      end
   end

   // ---------------- observed traffic ----------------
   int n_wr = 0, n_msix = 0, n_pin = 0;
   logic [31:0]  last_addr = '0;
   logic [127:0] last_data = '0;
   logic [4:0]   last_vec = '0;

   always @(posedge clk) begin
      if (rst_n && wr_valid && wr_ready) begin
         n_wr++; last_addr = wr_addr; last_data = wr_data;
      end
      if (rst_n && msix_valid) begin n_msix++; last_vec = msix_vector; end
      if (rst_n && pin_pulse) n_pin++;
   end

   task automatic send(input logic [15:0] cid, input logic [15:0] sq,
                       input logic [15:0] sh, input logic [14:0] code);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_cid = cid; cpl_sqid = sq; cpl_sqhead = sh; cpl_code = code;
      while (!cpl_ready) @(negedge clk);
      @(negedge clk);
      cpl_valid = 1'b0;
   endtask

   task automatic ring_db(input int h);
      @(negedge clk);
      db_valid = 1'b1; db_head = 12'(h);
      @(negedge clk);
      db_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      finish_run();
   end

   int s_wr, s_msix, s_pin, pushes;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      started = 1'b1;
      @(negedge clk);
      check("R1 reset wr_valid", 128'(wr_valid), 128'd0);
      check("R1 reset cpl_ready", 128'(cpl_ready), 128'd1);

      // first entry: slot 0, phase 1
      send(16'h0011, 16'h0002, 16'h0005, 15'h002);
      repeat (8) @(negedge clk);
      check("R3 first address", 128'(last_addr), 128'(BASE));
      check("R1 R2 first entry", last_data, {15'h002, 1'b1, 16'h0011, 16'h0002, 16'h0005, 64'd0});
      check("R8 msix after first", 128'(n_msix), 128'd1);
      check("R8 vector", 128'(last_vec), 128'd3);

      // back-to-back pair -> one interrupt
      send(16'h0022, 16'h0001, 16'h0007, 15'h000);
      send(16'h0033, 16'h0001, 16'h0008, 15'h004);
      repeat (10) @(negedge clk);
      check("R3 third address", 128'(last_addr), 128'(BASE + 32'h20));
      check("R8 one interrupt per batch", 128'(n_msix), 128'd2);

      // ring one short of full: hold
      send(16'h0044, 16'h0003, 16'h0001, 15'h001);
      repeat (10) @(negedge clk);
      check("R5 held while full", 128'(n_wr), 128'd3);
      check("R5 no request while full", 128'(wr_valid), 128'd0);

      ring_db(QSZ);
      repeat (6) @(negedge clk);
      check("R6 out-of-range doorbell ignored", 128'(n_wr), 128'd3);

      ring_db(1);
      repeat (8) @(negedge clk);
      check("R5 resumes after doorbell", 128'(n_wr), 128'd4);
      check("R4 last slot address", 128'(last_addr), 128'(BASE + 32'h30));

      // after wrap: slot 0 with phase 0
      ring_db(0);
      send(16'h0055, 16'h0000, 16'h0002, 15'h003);
      repeat (8) @(negedge clk);
      check("R4 wrapped address", 128'(last_addr), 128'(BASE));
      check("R4 phase inverted", 128'(last_data[112]), 128'd0);

      // pin mode
      cfg_msix_en = 1'b0;
      ring_db(m_tail);
      s_msix = n_msix; s_pin = n_pin;
      send(16'h0066, 16'h0001, 16'h0003, 15'h000);
      repeat (8) @(negedge clk);
      check("R8 pin pulse", 128'(n_pin), 128'(s_pin + 1));
      check("R8 no msix in pin mode", 128'(n_msix), 128'(s_msix));

      // interrupts off
      cfg_irq_en = 1'b0;
      ring_db(m_tail);
      s_msix = n_msix; s_pin = n_pin; s_wr = n_wr;
      send(16'h0077, 16'h0001, 16'h0004, 15'h000);
      repeat (8) @(negedge clk);
      check("R8 written with irq off", 128'(n_wr), 128'(s_wr + 1));
      check("R8 no pin when off", 128'(n_pin), 128'(s_pin));
      check("R8 no msix when off", 128'(n_msix), 128'(s_msix));

      // backpressure and buffer capacity
      cfg_irq_en = 1'b1; cfg_msix_en = 1'b1;
      ring_db(m_tail);
      wr_ready = 1'b0;
      s_wr = n_wr;
      send(16'h0088, 16'h0002, 16'h0009, 15'h005);
      repeat (6) @(negedge clk);
      check("R7 request held", 128'(wr_valid), 128'd1);
      check("R7 no accept without ready", 128'(n_wr), 128'(s_wr));
      pushes = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!cpl_ready) break;
         cpl_valid = 1'b1; cpl_cid = 16'(16'h0100 + i); cpl_sqid = 16'h0001;
         cpl_sqhead = 16'(i); cpl_code = 15'(i);
         pushes++;
      end
      cpl_valid = 1'b0;
      check("R9 buffer capacity", 128'(pushes), 128'(DEPTH));

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         cpl_valid  = ($urandom % 3) == 0;
         cpl_cid    = 16'($urandom);
         cpl_sqid   = 16'($urandom % 8);
         cpl_sqhead = 16'($urandom);
         cpl_code   = 15'($urandom);
         wr_ready   = ($urandom % 4) != 0;
         db_valid   = ($urandom % 5) == 0;
         db_head    = (($urandom % 4) == 0) ? 12'($urandom % 8) : 12'(m_tail);
         if ((i % 500) == 0) cfg_msix_en = !cfg_msix_en;
      end

      // drain
      cpl_valid = 1'b0; wr_ready = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         db_valid = 1'b1; db_head = 12'(m_tail);
      end
      @(negedge clk);
      db_valid = 1'b0;
      repeat (10) @(negedge clk);
      check("R9 all drained in order", 128'(wr_valid), 128'd0);
      check("R9 ready after drain", 128'(cpl_ready), 128'd1);

      finish_run();
   end

endmodule